// File: doc/BRIEF.md
# Energy Pulse Output Generator

This block turns a stream of signed real-power samples into pulse trains. Each accepted sample adds its magnitude to one accumulator. Each time the sum reaches a threshold, the block issues a calibration pulse on `cf` and subtracts the threshold. The two select bits `sel` set the threshold and so choose one of four frequency scalings. Samples whose magnitude is below a creep floor are dropped, so a meter with no load issues no pulses.

A ratio divider counts the calibration pulses and passes every Nth one on as a low-frequency step event. N is set by `cal_hi`. The step events are sent alternately to `f1` and `f2`. Each step pulse has a fixed width and the two phases never overlap, so the pair can drive a two-phase stepper motor or an electromechanical counter directly. `revp` gives the sign of the power. It is updated only on the edge where a calibration pulse starts.

While `rst_n` is low the block is held in reset and nothing is emitted.

Top module: `energy_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `f1`, `f2`, `cf` and `revp` are low from the next clock edge on. The accumulator, the ratio count and the phase are cleared, so the first step pulse after reset goes to `f1`.
- R2: On a clock edge where `pwr_valid` is high and |`pwr_sample`| >= CREEP_MIN, the magnitude is added to the accumulator. If the sum is at least the threshold, the threshold is subtracted and a crossing occurs. The threshold is BASE_TH >> `sel`: `sel`=0 gives the slowest rate and `sel`=3 the fastest. Only one threshold is subtracted per sample.
- R3: A sample with |`pwr_sample`| < CREEP_MIN leaves the accumulator unchanged and produces no pulse.
- R4: A crossing starts a `cf` pulse in the cycle after its sample. The pulse is high for exactly CF_PW cycles. A crossing that arrives while `cf` is high emits no pulse, but the threshold is still subtracted.
- R5: Every emitted `cf` pulse advances a ratio count. When the count reaches N, a step event occurs on that same edge and the count restarts. N is RATIO_HI when `cal_hi`=1 and RATIO_LO when `cal_hi`=0.
- R6: Step events alternate between `f1` and `f2`, starting with `f1`. Each step pulse is F_PW cycles high and starts on the same edge as its `cf` pulse. `f1` and `f2` are never high together. A step event that arrives while either phase is high is dropped and does not advance the phase.
- R7: `revp` takes the sign bit of the sample whose crossing emitted a `cf` pulse (1 means negative power). It changes only on the edge where `cf` rises. At all other times it holds.
- R8: Positive and negative samples of equal magnitude accumulate identically. They give the same pulse count and differ only in `revp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; low holds the block idle |
| pwr_valid | input | 1 | Strobe marking a new power sample |
| pwr_sample | input | PWR_W | Signed real-power sample, two's complement |
| sel | input | 2 | Frequency scaling select (threshold shift) |
| cal_hi | input | 1 | Chooses the CF-to-step ratio (1: RATIO_HI, 0: RATIO_LO) |
| f1 | output | 1 | Step phase one |
| f2 | output | 1 | Step phase two |
| cf | output | 1 | Calibration pulse |
| revp | output | 1 | Reverse-power flag |

## Verification
The hardest cases to reach are the dropped events. A `cf` crossing is dropped only if a second crossing lands inside a `cf` pulse, and a step event is dropped only if it lands inside a step pulse. With ordinary sample sizes neither happens. The bench therefore builds the block with a small high-side ratio. It then feeds near-full-scale samples on every cycle at the fastest select. This puts crossings inside `cf` pulses and step events inside step pulses, and the reference model predicts which are kept and which are lost. Sign changes at this rate also show that `revp` ignores the samples between emitted pulses.

// File: rtl/energy_pulse_pkg.sv
package energy_pulse_pkg;

  typedef enum logic {PH_F1 = 1'b0, PH_F2 = 1'b1} fphase_e;

  // Magnitude of a sign-extended sample
  function automatic logic [31:0] abs_mag(input logic signed [31:0] v);
    return v[31] ? 32'(-v) : 32'(v);
  endfunction

  // Crossing threshold for a frequency select code
  function automatic logic [31:0] cf_threshold(input int base, input logic [1:0] sel);
    return 32'(base) >> sel;
  endfunction

  // Number of CF pulses per step event
  function automatic logic [31:0] cf_ratio(input int lo, input int hi, input logic cal_hi);
    return cal_hi ? 32'(hi) : 32'(lo);
  endfunction

endpackage

// File: rtl/epg_accum.sv
module epg_accum #(
  parameter int PWR_W     = 16,
  parameter int BASE_TH   = 1 << 18,
  parameter int CREEP_MIN = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_valid,
  input  logic signed [PWR_W-1:0] pwr_sample,
  input  logic [1:0]              sel,
  output logic                    cross_fire
);
  import energy_pulse_pkg::*;

  localparam int ACC_W = $clog2(BASE_TH) + 2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] mag_w;
  logic [ACC_W-1:0] th_w;
  logic [ACC_W-1:0] sum_w;
  logic             above_creep;
  logic             accept;

  assign mag_w       = ACC_W'(abs_mag(32'(pwr_sample)));
  assign th_w        = ACC_W'(cf_threshold(BASE_TH, sel));
  assign above_creep = mag_w >= ACC_W'(CREEP_MIN);
  assign accept      = pwr_valid && above_creep;
  assign sum_w       = acc_q + mag_w;
  assign cross_fire  = accept && (sum_w >= th_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (cross_fire) begin
      acc_q <= sum_w - th_w;
    end else if (accept) begin
      acc_q <= sum_w;
    end
  end

  // R3
  creep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_valid && !above_creep) |=> $stable(acc_q));

  // R2
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(acc_q) < 32'(BASE_TH) + (32'd1 << (PWR_W - 1)));

endmodule

// File: rtl/epg_pulse.sv
module epg_pulse #(
  parameter int PW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic taken,
  output logic busy,
  output logic pulse
);
  localparam int CNT_W = $clog2(PW + 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy  = cnt_q != '0;
  assign pulse = busy;
  assign taken = fire && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (taken) begin
      cnt_q <= CNT_W'(PW);
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(fire));

  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && busy) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/epg_ratio.sv
module epg_ratio #(
  parameter int RATIO_LO = 64,
  parameter int RATIO_HI = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cf_taken,
  input  logic cal_hi,
  output logic step_evt
);
  import energy_pulse_pkg::*;

  localparam int RMAX  = (RATIO_LO > RATIO_HI) ? RATIO_LO : RATIO_HI;
  localparam int DIV_W = $clog2(RMAX + 1);

  logic [DIV_W-1:0] div_q;
  logic [31:0]      next_cnt;

  assign next_cnt = 32'(div_q) + 32'd1;
  assign step_evt = cf_taken && (next_cnt >= cf_ratio(RATIO_LO, RATIO_HI, cal_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (step_evt) begin
      div_q <= '0;
    end else if (cf_taken) begin
      div_q <= DIV_W'(next_cnt);
    end
  end

  // R5
  step_needs_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> cf_taken);

  // R5
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(div_q) < 32'(RMAX));

endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen #(
  parameter int PWR_W     = 16,
  parameter int BASE_TH   = 1 << 18,
  parameter int CREEP_MIN = 256,
  parameter int CF_PW     = 4,
  parameter int F_PW      = 32,
  parameter int RATIO_LO  = 64,
  parameter int RATIO_HI  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_valid,
  input  logic signed [PWR_W-1:0] pwr_sample,
  input  logic [1:0]              sel,
  input  logic                    cal_hi,
  output logic                    f1,
  output logic                    f2,
  output logic                    cf,
  output logic                    revp
);
  import energy_pulse_pkg::*;

  localparam int NPH = 2;

  logic           cross_fire;
  logic           cf_taken;
  logic           cf_busy;
  logic           step_evt;
  logic           revp_q;
  fphase_e        ph_q;
  logic [NPH-1:0] f_fire;
  logic [NPH-1:0] f_taken;
  logic [NPH-1:0] f_busy;
  logic [NPH-1:0] f_pulse;
  logic           f_any_busy;

  epg_accum #(
    .PWR_W    (PWR_W),
    .BASE_TH  (BASE_TH),
    .CREEP_MIN(CREEP_MIN)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_valid (pwr_valid),
    .pwr_sample(pwr_sample),
    .sel       (sel),
    .cross_fire(cross_fire)
  );

  epg_pulse #(.PW(CF_PW)) u_cf_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (cross_fire),
    .taken(cf_taken),
    .busy (cf_busy),
    .pulse(cf)
  );

  epg_ratio #(
    .RATIO_LO(RATIO_LO),
    .RATIO_HI(RATIO_HI)
  ) u_ratio (
    .clk     (clk),
    .rst_n   (rst_n),
    .cf_taken(cf_taken),
    .cal_hi  (cal_hi),
    .step_evt(step_evt)
  );

  assign f_any_busy = |f_busy;

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    assign f_fire[i] = step_evt && !f_any_busy &&
                       (ph_q == ((i == 0) ? PH_F1 : PH_F2));
    epg_pulse #(.PW(F_PW)) u_f_pulse (
      .clk  (clk),
      .rst_n(rst_n),
      .fire (f_fire[i]),
      .taken(f_taken[i]),
      .busy (f_busy[i]),
      .pulse(f_pulse[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_F1;
    end else if (|f_taken) begin
      ph_q <= (ph_q == PH_F1) ? PH_F2 : PH_F1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      revp_q <= 1'b0;
    end else if (cf_taken) begin
      revp_q <= pwr_sample[PWR_W-1];
    end
  end

  assign f1   = f_pulse[0];
  assign f2   = f_pulse[1];
  assign revp = revp_q;

  // R6
  f_phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(f1 && f2));

  // R6
  f_with_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(f1) || $rose(f2)) |-> $rose(cf));

  // R7
  revp_at_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (revp != $past(revp)) |-> $rose(cf));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!cf && !f1 && !f2 && !revp));

  // R6
  single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(f_taken));

endmodule

// File: tb/energy_pulse_gen_tb.sv
module energy_pulse_gen_tb;

  localparam int PWR_W     = 16;
  localparam int BASE_TH   = 1 << 18;
  localparam int CREEP_MIN = 256;
  localparam int CF_PW     = 4;
  localparam int F_PW      = 20;
  localparam int RATIO_LO  = 16;
  localparam int RATIO_HI  = 4;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    pwr_valid = 1'b0;
  logic signed [PWR_W-1:0] pwr_sample = '0;
  logic [1:0]              sel = 2'd0;
  logic                    cal_hi = 1'b0;
  logic                    f1, f2, cf, revp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_acc, m_cfc, m_div, m_f1c, m_f2c, m_ph;
  bit m_revp;
  // rise counters on DUT outputs
  int n_cf, n_f1, n_f2;
  logic p_cf, p_f1, p_f2;

  energy_pulse_gen #(
    .PWR_W(PWR_W), .BASE_TH(BASE_TH), .CREEP_MIN(CREEP_MIN),
    .CF_PW(CF_PW), .F_PW(F_PW), .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_valid(pwr_valid), .pwr_sample(pwr_sample),
    .sel(sel), .cal_hi(cal_hi), .f1(f1), .f2(f2), .cf(cf), .revp(revp)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int mag, th, ratio;
    bit fire, emit, fev, fbusy;
    if (!rst_n) begin
      m_acc = 0; m_cfc = 0; m_div = 0; m_f1c = 0; m_f2c = 0; m_ph = 0; m_revp = 0;
      return;
    end
    fire = 0;
    if (pwr_valid) begin
      mag = (int'(pwr_sample) < 0) ? -int'(pwr_sample) : int'(pwr_sample);
      if (mag >= CREEP_MIN) begin
        th = BASE_TH / (1 << sel);
        if (m_acc + mag >= th) begin
          fire = 1;
          m_acc = m_acc + mag - th;
        end else begin
          m_acc = m_acc + mag;
        end
      end
    end
    emit = fire && (m_cfc == 0);
    if (emit) m_cfc = CF_PW;
    else if (m_cfc > 0) m_cfc--;
    fev = 0;
    if (emit) begin
      m_revp = int'(pwr_sample) < 0;
      ratio = cal_hi ? RATIO_HI : RATIO_LO;
      if (m_div + 1 >= ratio) begin
        fev = 1;
        m_div = 0;
      end else begin
        m_div++;
      end
    end
    fbusy = (m_f1c != 0) || (m_f2c != 0);
    if (m_f1c > 0) m_f1c--;
    if (m_f2c > 0) m_f2c--;
    if (fev && !fbusy) begin
      if (m_ph == 0) m_f1c = F_PW;
      else m_f2c = F_PW;
      m_ph = 1 - m_ph;
    end
  endtask

  always @(posedge clk) begin
    model_step();
    #1;
    if (!done) begin
      check("R4", "cf", int'(cf), int'(m_cfc != 0));
      check("R6", "f1", int'(f1), int'(m_f1c != 0));
      check("R6", "f2", int'(f2), int'(m_f2c != 0));
      check("R7", "revp", int'(revp), int'(m_revp));
      if (cf && !p_cf) n_cf++;
      if (f1 && !p_f1) n_f1++;
      if (f2 && !p_f2) n_f2++;
      p_cf = cf; p_f1 = f1; p_f2 = f2;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pwr_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_cf = 0; n_f1 = 0; n_f2 = 0;
  endtask

  task automatic feed(input int n, input int val);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pwr_valid = 1'b1;
      pwr_sample = PWR_W'(val);
    end
    @(negedge clk);
    pwr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    $display("FAIL watchdog expired actual=running expected=finished");
    errors++;
    checks++;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    p_cf = 0; p_f1 = 0; p_f2 = 0;
    n_cf = 0; n_f1 = 0; n_f2 = 0;
    // R1: reset state
    idle(3);
    check("R1", "cf in reset", int'(cf), 0);
    check("R1", "f1|f2 in reset", int'(f1 | f2), 0);
    check("R1", "revp in reset", int'(revp), 0);
    rst_n = 1'b1;

    // R3: sub-creep samples never pulse
    sel = 2'd3;
    feed(2000, CREEP_MIN - 1);
    feed(2000, -(CREEP_MIN - 1));
    idle(10);
    check("R3", "cf count below creep", n_cf, 0);

    // R2 / R8: positive, slowest select: 600*2000 / 262144 -> 4
    do_reset();
    sel = 2'd0; cal_hi = 1'b0;
    feed(600, 2000);
    idle(10);
    check("R2", "cf count sel0 positive", n_cf, 4);
    check("R7", "revp after positive", int'(revp), 0);

    // R8: same magnitude negative
    do_reset();
    feed(600, -2000);
    idle(10);
    check("R8", "cf count sel0 negative", n_cf, 4);
    check("R7", "revp after negative", int'(revp), 1);

    // R5 / R6: sel2 th=65536, 8192 per cycle -> 32 cf, ratio 4 -> 8 steps
    do_reset();
    sel = 2'd2; cal_hi = 1'b1;
    feed(256, 8192);
    idle(40);
    check("R2", "cf count sel2", n_cf, 32);
    check("R5", "f1 steps ratio hi", n_f1, 4);
    check("R6", "f2 steps ratio hi", n_f2, 4);

    // R5: ratio lo 16 -> 2 steps, first on f1 after reset
    do_reset();
    cal_hi = 1'b0;
    feed(256, 8192);
    idle(40);
    check("R5", "f1 steps ratio lo", n_f1, 1);
    check("R5", "f2 steps ratio lo", n_f2, 1);

    // R4 / R6: full-scale at fastest select, drops in cf and steps
    do_reset();
    sel = 2'd3; cal_hi = 1'b1;
    feed(400, 32767);
    feed(400, -32768);
    idle(40);
    check("R4", "cf thinned by busy", int'(n_cf < 800), 1);

    // mixed random stimulus, model compared each cycle (R2 R7)
    do_reset();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if ((k % 3000) == 0) begin
        sel = 2'($urandom_range(0, 3));
        cal_hi = 1'($urandom_range(0, 1));
      end
      pwr_valid = 1'($urandom_range(0, 3) != 0);
      pwr_sample = PWR_W'(int'($urandom_range(0, 65535)) - 32768);
      if (k == 12000) rst_n = 1'b0;
      if (k == 12003) rst_n = 1'b1;
    end
    @(negedge clk);
    pwr_valid = 1'b0;
    idle(40);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule